// File: doc/BRIEF.md
# Bidirectional Token Row Scanner

This block selects one display row at a time for a scanned row driver. It holds a chain of single-bit stages, one per row output. A high level on the active end pin at a rising clock edge clears the whole chain and places a single active bit in the first stage. On each later edge where that pin is low, the bit moves one stage further along. The bit leaves the chain after the last stage, and the chain is then empty.

Two bidirectional end pins carry the serial data. A direction input decides which end pin is the input and which end pin carries the cascade output. The block drives the output pin and leaves the input pin undriven. The cascade output shows the last stage in the current direction, so the next device's input can follow it.

Each row output is passed through a polarity stage. A single enable-style input can put every row output into high impedance. This block has no streaming data interface: all of its pins are plain levels sampled on the clock.

Top module: `row_token_scanner`

## Requirements
- R1: While `rst_n` is low, every stage is cleared. After reset, with `pol`=1 and `hiz_all`=0, every `row_out` bit reads 0 and the cascade output pin reads 0.
- R2: If the selected input pin is 1 at a rising edge, then after that edge only the first stage in the current direction holds 1 and every other stage holds 0. With `fwd`=1 the first stage is `row_out[0]`. With `fwd`=0 the first stage is `row_out[STAGES-1]`.
- R3: If the input pin is 0 at a rising edge, every stage takes the value of its neighbour toward the input end, and a 0 enters the first stage. With `fwd`=1 the bits move toward higher indices. With `fwd`=0 they move toward lower indices.
- R4: An injection restarts the chain at the first stage even while an earlier token is still part-way along. The earlier token is discarded, and at most one stage is ever active.
- R5: With `fwd`=1, `end_a` is the input and the block leaves it undriven. `end_b` is the output and is driven with the value of stage `STAGES-1`.
- R6: With `fwd`=0, `end_b` is the input and the block leaves it undriven. `end_a` is the output and is driven with the value of stage 0.
- R7: An active stage drives its row output to the value of `pol`. An inactive stage drives the inverse of `pol`.
- R8: While `hiz_all`=1, every `row_out` bit is high impedance. The chain keeps shifting during this time, so the row outputs show the advanced state once `hiz_all` returns to 0.
- R9: A token that shifts past the last stage leaves the chain empty. The cascade output is 1 for exactly the one cycle in which the token sits in the last stage.
- R10: Changing `fwd` does not change the stored stages. The next shifts move the stored bit in the new direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock; stages update on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset that clears the chain |
| fwd | input | 1 | Direction select: 1 makes `end_a` the input, 0 makes `end_b` the input |
| pol | input | 1 | Level that an active row drives |
| hiz_all | input | 1 | 1 puts every row output into high impedance |
| end_a | inout | 1 | End pin next to stage 0 |
| end_b | inout | 1 | End pin next to stage STAGES-1 |
| row_out | output | STAGES | Row select outputs, after polarity and tri-state control |

## Verification
The bench builds the block with `STAGES`=6. With this short chain, a token crosses the whole chain, appears on the cascade pin and drops off the end within a few cycles, in both directions. At this length a restart in mid-chain, a reversal in mid-chain and a high-impedance period can each be placed where the token's position after the event is unambiguous. A scoreboard follows a reference model of the chain. It checks the row outputs and the cascade pin, including the high-impedance values, after every edge.

// File: rtl/rts_pkg.sv
package rts_pkg;
  typedef enum logic {
    DIR_B_TO_A = 1'b0,
    DIR_A_TO_B = 1'b1
  } scan_dir_e;
endpackage

// File: rtl/rts_shift_chain.sv
module rts_shift_chain
  import rts_pkg::*;
#(
  parameter int STAGES = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fwd,
  input  logic              inj,
  output logic [STAGES-1:0] stages
);
  localparam logic [STAGES-1:0] HEAD_LOW  = {{(STAGES-1){1'b0}}, 1'b1};
  localparam logic [STAGES-1:0] HEAD_HIGH = {1'b1, {(STAGES-1){1'b0}}};

  scan_dir_e dir;
  assign dir = scan_dir_e'(fwd);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stages <= '0;
    end else if (inj) begin
      stages <= (dir == DIR_A_TO_B) ? HEAD_LOW : HEAD_HIGH;
    end else if (dir == DIR_A_TO_B) begin
      stages <= {stages[STAGES-2:0], 1'b0};
    end else begin
      stages <= {1'b0, stages[STAGES-1:1]};
    end
  end

  // R2: injection lands on the first stage of the direction in force
  p_inject_head_r2: assert property (@(posedge clk) disable iff (!rst_n)
    inj |=> stages == ($past(fwd) ? HEAD_LOW : HEAD_HIGH));

  // R4: never more than one active stage
  p_single_token_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(stages));

  // R3: without injection the active count never grows
  p_no_growth_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !inj |=> $countones(stages) <= $countones($past(stages)));
endmodule

// File: rtl/rts_end_pins.sv
module rts_end_pins
  import rts_pkg::*;
#(
  parameter int STAGES = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fwd,
  input  logic              pin_a_in,
  input  logic              pin_b_in,
  input  logic [STAGES-1:0] stages,
  output logic              inj,
  output logic              ser_out,
  output logic              drive_a,
  output logic              drive_b
);
  scan_dir_e dir;
  assign dir     = scan_dir_e'(fwd);
  assign inj     = (dir == DIR_A_TO_B) ? pin_a_in : pin_b_in;
  assign ser_out = (dir == DIR_A_TO_B) ? stages[STAGES-1] : stages[0];
  assign drive_a = (dir == DIR_B_TO_A);
  assign drive_b = (dir == DIR_A_TO_B);

  // R5 / R6: exactly one end pin is driven by the block
  p_one_driver_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot({drive_a, drive_b}));

  // R9: the cascade output is only high when an end stage holds the token
  p_cascade_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ser_out |-> (stages[0] || stages[STAGES-1]));
endmodule

// File: rtl/rts_row_drive.sv
module rts_row_drive #(
  parameter int STAGES = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pol,
  input  logic [STAGES-1:0] stages,
  output logic [STAGES-1:0] levels
);
  for (genvar g = 0; g < STAGES; g++) begin : g_row
    assign levels[g] = ~(stages[g] ^ pol);
  end

  // R7: rows at the pol level match the number of active stages
  p_pol_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pol |-> $countones(levels) == $countones(stages));

  p_pol_inv_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !pol |-> $countones(~levels) == $countones(stages));
endmodule

// File: rtl/row_token_scanner.sv
module row_token_scanner #(
  parameter int STAGES = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fwd,
  input  logic              pol,
  input  logic              hiz_all,
  inout  wire               end_a,
  inout  wire               end_b,
  output logic [STAGES-1:0] row_out
);
  logic [STAGES-1:0] stages;
  logic [STAGES-1:0] levels;
  logic              inj;
  logic              ser_out;
  logic              drive_a;
  logic              drive_b;
  logic              pin_a_in;
  logic              pin_b_in;

  assign pin_a_in = end_a;
  assign pin_b_in = end_b;

  rts_end_pins #(.STAGES(STAGES)) u_pins (
    .clk(clk), .rst_n(rst_n), .fwd(fwd),
    .pin_a_in(pin_a_in), .pin_b_in(pin_b_in), .stages(stages),
    .inj(inj), .ser_out(ser_out), .drive_a(drive_a), .drive_b(drive_b)
  );

  rts_shift_chain #(.STAGES(STAGES)) u_chain (
    .clk(clk), .rst_n(rst_n), .fwd(fwd), .inj(inj), .stages(stages)
  );

  rts_row_drive #(.STAGES(STAGES)) u_drive (
    .clk(clk), .rst_n(rst_n), .pol(pol), .stages(stages), .levels(levels)
  );

  assign end_a   = drive_a ? ser_out : 1'bz;
  assign end_b   = drive_b ? ser_out : 1'bz;
  assign row_out = hiz_all ? {STAGES{1'bz}} : levels;
endmodule

// File: tb/row_token_scanner_tb_top.sv
module row_token_scanner_tb_top;
  localparam int N = 6;

  typedef struct {
    logic [N-1:0] row;
    logic         ser;
    logic         fwd;
    string        tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fwd = 1'b1;
  logic pol = 1'b1;
  logic hiz_all = 1'b0;
  logic tb_val = 1'b0;
  wire  end_a, end_b;
  logic [N-1:0] row_out;

  assign end_a = fwd  ? tb_val : 1'bz;
  assign end_b = !fwd ? tb_val : 1'bz;

  row_token_scanner #(.STAGES(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .fwd(fwd), .pol(pol), .hiz_all(hiz_all),
    .end_a(end_a), .end_b(end_b), .row_out(row_out)
  );

  always #2 clk = ~clk;

  int checks = 0;
  int errors = 0;
  logic [N-1:0] model = '0;
  exp_t q[$];
  bit done = 1'b0;

  task automatic check(input string tag, input logic [N-1:0] act,
                       input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  // driver: sets inputs at the falling edge and predicts the next rising edge
  task automatic step(input logic d, input logic p, input logic h,
                      input logic in_bit, input string tag);
    exp_t e;
    @(negedge clk);
    fwd = d; pol = p; hiz_all = h; tb_val = in_bit;
    if (in_bit) model = d ? {{(N-1){1'b0}}, 1'b1} : {1'b1, {(N-1){1'b0}}};
    else        model = d ? (model << 1) : (model >> 1);
    e.row = h ? {N{1'bz}} : (p ? model : ~model);
    e.ser = d ? model[N-1] : model[0];
    e.fwd = d;
    e.tag = tag;
    q.push_back(e);
  endtask

  // monitor: compares just after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        check({e.tag, " rows"}, row_out, e.row);
        check({e.tag, " cascade"}, {{(N-1){1'b0}}, (e.fwd ? end_b : end_a)},
              {{(N-1){1'b0}}, e.ser});
      end
    end
  end

  initial begin
    #200000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset rows", row_out, '0);
    check("R1 reset cascade", {{(N-1){1'b0}}, end_b}, '0);
    rst_n = 1'b1;
    // R2 inject forward, R3 shift
    step(1, 1, 0, 1, "R2");
    step(1, 1, 0, 0, "R3");
    step(1, 1, 0, 0, "R3");
    // R4 restart mid-chain
    step(1, 1, 0, 1, "R4");
    step(1, 1, 0, 0, "R4");
    step(1, 1, 0, 0, "R3");
    step(1, 1, 0, 0, "R3");
    step(1, 1, 0, 0, "R5");
    step(1, 1, 0, 0, "R9");
    step(1, 1, 0, 0, "R9");
    // R7 polarity low
    step(1, 0, 0, 1, "R7");
    step(1, 0, 0, 0, "R7");
    // R8 high impedance while shifting
    step(1, 0, 1, 0, "R8");
    step(1, 1, 1, 0, "R8");
    step(1, 1, 0, 0, "R8");
    // R6 reverse direction
    step(0, 1, 0, 1, "R6");
    step(0, 1, 0, 0, "R6");
    step(0, 1, 0, 0, "R3");
    step(0, 1, 0, 1, "R4");
    for (int i = 0; i < N - 1; i++) step(0, 1, 0, 0, "R6");
    step(0, 1, 0, 0, "R9");
    // R10 reverse mid-chain
    step(0, 1, 0, 1, "R10");
    step(0, 1, 0, 0, "R10");
    step(1, 1, 0, 0, "R10");
    step(1, 1, 0, 0, "R10");
    step(1, 0, 0, 0, "R10");
    repeat (3) @(negedge clk);
    // R5: block leaves the input pin to the bench driver
    fwd = 1'b1; tb_val = 1'b1; #1;
    check("R5 input pin undriven", {{(N-1){1'b0}}, end_a}, {{(N-1){1'b0}}, 1'b1});
    tb_val = 1'b0;
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule